// File: doc/BRIEF.md
# Load-Adaptive Switching Frequency Generator

This block sets the switching-period timing of a flyback PWM controller. A digitised feedback code serves as its measure of load, and the block turns that code into a switching period counted in system-clock ticks. It emits a one-cycle cycle-start strobe at every period boundary and reports the length of the cycle that has just begun. At heavy load the period stays at a nominal length. Across a middle band of codes the period grows linearly. Below that band it is clamped at a long floor period.

A triangular dither is added to the period to spread the emitted spectrum. The dither offset is a fixed fraction of the base period, so its amplitude follows the operating point. The dither advances once per emitted cycle, so its sweep time in real time grows as the switching frequency falls.

At very light load a hysteretic burst gate suppresses whole switching cycles. The period counter keeps running while cycles are suppressed, so switching restarts exactly on a cycle boundary. The period is reloaded only at a boundary, so a change of load code never shortens or stretches a cycle already under way.

Top module: `lafg_freq_gen`

## Requirements
- R1: While reset is held, `cyc_start_o` is 0 and `period_o` equals `P_NOM`. The first strobe after reset release comes exactly `P_NOM` clock edges after release, and the dither level restarts at 0 with its direction rising.
- R2: A feedback code at or above `TH_NOM` gives a base period of `P_NOM`.
- R3: A code strictly between `TH_FLOOR` and `TH_NOM` gives a base period of `P_NOM + (TH_NOM - code) * STEP`, where `STEP = (P_FLOOR - P_NOM) / (TH_NOM - TH_FLOOR)` (integer division).
- R4: A code at or below `TH_FLOOR` gives a base period of `P_FLOOR`.
- R5: Each new period equals `base + floor(h * base / 2^HOP_SHIFT)`, where `h` is the signed dither level and `base` is computed from the feedback code sampled at the period boundary.
- R6: The dither level starts at 0 and moves by one per emitted cycle. It rises until it reaches `+HOP_SPAN`, then falls until it reaches `-HOP_SPAN`, then rises again.
- R7: The number of clock edges between two consecutive strobes equals the `period_o` value shown with the first of the two. A code change in mid-cycle does not alter the length of that cycle.
- R8: Once the code is below `TH_ZDC` at a clock edge, no strobe is emitted from the second following edge onward, until switching resumes.
- R9: Suppression ends only when the code is at or above `TH_RESUME`. A code of exactly `TH_ZDC` never starts suppression.
- R10: While cycles are suppressed, period boundaries keep occurring and the dither level is frozen. The first strobe after resume therefore falls on a boundary of the running period chain, and its period uses the frozen level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all periods are counted in its ticks |
| rst_ni | input | 1 | Active-low synchronous reset |
| fb_code_i | input | FB_W | Digitised feedback (load) code, 1 LSB = 25 mV by default |
| cyc_start_o | output | 1 | One-cycle strobe marking the start of a switching cycle |
| period_o | output | PER_W | Length in ticks of the cycle that has started |

## Verification
The bench drives codes on each side of every threshold and includes the exact threshold codes. A design that compared with the wrong sense at `TH_NOM`, `TH_FLOOR` or `TH_ZDC` would show a base period one step off, or would start suppression one code too early. Negative dither levels check that the offset is floored rather than truncated toward zero; sign-magnitude rounding would make those periods one tick too long. A code change in the middle of a cycle catches a design that reloads the period at any time other than a boundary, because the spacing between strobes would then no longer match the reported period. The burst sequence checks that a code between the two burst thresholds keeps switching suppressed. It also checks that restart lands on a multiple of the frozen period and uses the frozen dither level: a design that stopped its counter or kept stepping the dither would miss one or both.

// File: rtl/lafg_pkg.sv
package lafg_pkg;

    // Sweep direction of the triangular dither
    typedef enum logic {
        HOP_RISE = 1'b0,
        HOP_FALL = 1'b1
    } hop_dir_e;

    // Burst gate state
    typedef enum logic {
        GATE_RUN  = 1'b0,
        GATE_HOLD = 1'b1
    } burst_st_e;

endpackage

// File: rtl/lafg_period_map.sv
// Piecewise mapping of the load code to a base switching period.
module lafg_period_map #(
    parameter int FB_W     = 8,
    parameter int PER_W    = 16,
    parameter int P_NOM    = 1538,
    parameter int P_FLOOR  = 4444,
    parameter int TH_NOM   = 100,
    parameter int TH_FLOOR = 88
) (
    input  logic [FB_W-1:0]  fb_i,
    output logic [PER_W-1:0] base_o
);
    localparam int STEP = (P_FLOOR - P_NOM) / (TH_NOM - TH_FLOOR);

    localparam logic [FB_W-1:0]  TH_NOM_C   = FB_W'(TH_NOM);
    localparam logic [FB_W-1:0]  TH_FLOOR_C = FB_W'(TH_FLOOR);
    localparam logic [PER_W-1:0] P_NOM_C    = PER_W'(P_NOM);
    localparam logic [PER_W-1:0] P_FLOOR_C  = PER_W'(P_FLOOR);
    localparam logic [PER_W-1:0] STEP_C     = PER_W'(STEP);

    logic [FB_W-1:0] depth;

    always_comb begin
        depth = TH_NOM_C - fb_i;
        if (fb_i >= TH_NOM_C) begin
            base_o = P_NOM_C;
        end else if (fb_i <= TH_FLOOR_C) begin
            base_o = P_FLOOR_C;
        end else begin
            base_o = P_NOM_C + PER_W'(depth) * STEP_C;
        end
    end

endmodule

// File: rtl/lafg_hop_dither.sv
// Triangular dither level with an offset proportional to the base period.
module lafg_hop_dither
    import lafg_pkg::*;
#(
    parameter int PER_W     = 16,
    parameter int HOP_SPAN  = 72,
    parameter int HOP_SHIFT = 10
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    adv_i,
    input  logic [PER_W-1:0]        base_i,
    output logic signed [PER_W:0]   off_o
);
    localparam int LVL_W  = $clog2(HOP_SPAN + 1) + 1;
    localparam int PROD_W = LVL_W + PER_W + 1;

    localparam logic signed [LVL_W-1:0] SPAN_P = LVL_W'(HOP_SPAN);
    localparam logic signed [LVL_W-1:0] SPAN_N = -SPAN_P;
    localparam logic signed [LVL_W-1:0] ONE    = LVL_W'(1);

    typedef struct packed {
        logic signed [LVL_W-1:0] lvl;
        hop_dir_e                dir;
    } hop_st_t;

    hop_st_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            if (st_q.dir == HOP_RISE) begin
                st_d.lvl = st_q.lvl + ONE;
                if (st_d.lvl == SPAN_P) begin
                    st_d.dir = HOP_FALL;
                end
            end else begin
                st_d.lvl = st_q.lvl - ONE;
                if (st_d.lvl == SPAN_N) begin
                    st_d.dir = HOP_RISE;
                end
            end
        end
        // Signed product, arithmetic shift gives floor rounding
        prod  = PROD_W'(st_q.lvl) * $signed({{LVL_W{1'b0}}, 1'b0, base_i});
        off_o = (PER_W + 1)'(prod >>> HOP_SHIFT);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.lvl <= '0;
            st_q.dir <= HOP_RISE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lafg_burst_gate.sv
// Hysteretic cycle-suppression gate for very light load.
module lafg_burst_gate
    import lafg_pkg::*;
#(
    parameter int FB_W      = 8,
    parameter int TH_ZDC    = 64,
    parameter int TH_RESUME = 70
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [FB_W-1:0] fb_i,
    output logic            hold_o
);
    localparam logic [FB_W-1:0] ZDC_C    = FB_W'(TH_ZDC);
    localparam logic [FB_W-1:0] RESUME_C = FB_W'(TH_RESUME);

    burst_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            GATE_RUN:  if (fb_i < ZDC_C)     st_d = GATE_HOLD;
            GATE_HOLD: if (fb_i >= RESUME_C) st_d = GATE_RUN;
            default:   st_d = GATE_RUN;
        endcase
        hold_o = (st_q == GATE_HOLD);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= GATE_RUN;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lafg_freq_gen.sv
// Top: period timer combining base map, dither and burst gate.
module lafg_freq_gen #(
    parameter int FB_W      = 8,
    parameter int PER_W     = 16,
    parameter int P_NOM     = 1538,
    parameter int P_FLOOR   = 4444,
    parameter int TH_NOM    = 100,
    parameter int TH_FLOOR  = 88,
    parameter int TH_ZDC    = 64,
    parameter int TH_RESUME = 70,
    parameter int HOP_SPAN  = 72,
    parameter int HOP_SHIFT = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [FB_W-1:0]  fb_code_i,
    output logic             cyc_start_o,
    output logic [PER_W-1:0] period_o
);
    localparam logic [PER_W-1:0] P_NOM_C = PER_W'(P_NOM);
    localparam logic [PER_W-1:0] ONE_C   = PER_W'(1);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic             strobe;
    } tmr_t;

    tmr_t t_d, t_q;

    logic [PER_W-1:0]     base;
    logic signed [PER_W:0] off;
    logic                 hold;
    logic                 wrap;
    logic                 adv;
    logic [PER_W-1:0]     next_per;

    lafg_period_map #(
        .FB_W    (FB_W),
        .PER_W   (PER_W),
        .P_NOM   (P_NOM),
        .P_FLOOR (P_FLOOR),
        .TH_NOM  (TH_NOM),
        .TH_FLOOR(TH_FLOOR)
    ) u_map (
        .fb_i  (fb_code_i),
        .base_o(base)
    );

    lafg_hop_dither #(
        .PER_W    (PER_W),
        .HOP_SPAN (HOP_SPAN),
        .HOP_SHIFT(HOP_SHIFT)
    ) u_hop (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .adv_i (adv),
        .base_i(base),
        .off_o (off)
    );

    lafg_burst_gate #(
        .FB_W     (FB_W),
        .TH_ZDC   (TH_ZDC),
        .TH_RESUME(TH_RESUME)
    ) u_gate (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .fb_i  (fb_code_i),
        .hold_o(hold)
    );

    always_comb begin
        t_d        = t_q;
        t_d.strobe = 1'b0;
        wrap       = (t_q.cnt == (t_q.per - ONE_C));
        adv        = wrap && !hold;
        next_per   = PER_W'($signed({1'b0, base}) + off);
        if (wrap) begin
            t_d.cnt    = '0;
            t_d.per    = next_per;
            t_d.strobe = !hold;
        end else begin
            t_d.cnt = t_q.cnt + ONE_C;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            t_q.cnt    <= '0;
            t_q.per    <= P_NOM_C;
            t_q.strobe <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cyc_start_o = t_q.strobe;
    assign period_o    = t_q.per;

endmodule

// File: rtl/lafg_freq_gen_chk.sv
// Property checker attached to the top module.
module lafg_freq_gen_chk #(
    parameter int FB_W      = 8,
    parameter int PER_W     = 16,
    parameter int P_NOM     = 1538,
    parameter int P_FLOOR   = 4444,
    parameter int TH_ZDC    = 64,
    parameter int HOP_SPAN  = 72,
    parameter int HOP_SHIFT = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [FB_W-1:0]  fb_code_i,
    input logic             cyc_start_o,
    input logic [PER_W-1:0] period_o
);
    localparam int MIN_P = P_NOM - ((HOP_SPAN * P_NOM) >> HOP_SHIFT) - 1;
    localparam int MAX_P = P_FLOOR + ((HOP_SPAN * P_FLOOR) >> HOP_SHIFT);

    logic [31:0]      since_q;
    logic [PER_W-1:0] plen_q;
    logic             armed_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            since_q <= '0;
            plen_q  <= '0;
            armed_q <= 1'b0;
        end else if (cyc_start_o) begin
            since_q <= 32'd1;
            plen_q  <= period_o;
            armed_q <= 1'b1;
        end else if (since_q != 32'hFFFF_FFFF) begin
            since_q <= since_q + 32'd1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (period_o == PER_W'(P_NOM)) && !cyc_start_o);

    a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_start_o |=> !cyc_start_o);

    a_r7_no_early_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && cyc_start_o) |-> (since_q >= 32'(plen_q)));

    a_r5_period_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(period_o) >= 32'(MIN_P)) && (32'(period_o) <= 32'(MAX_P)));

    a_r8_burst_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fb_code_i < FB_W'(TH_ZDC)) |-> ##2 !cyc_start_o);

endmodule

bind lafg_freq_gen lafg_freq_gen_chk #(
    .FB_W     (FB_W),
    .PER_W    (PER_W),
    .P_NOM    (P_NOM),
    .P_FLOOR  (P_FLOOR),
    .TH_ZDC   (TH_ZDC),
    .HOP_SPAN (HOP_SPAN),
    .HOP_SHIFT(HOP_SHIFT)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fb_code_i  (fb_code_i),
    .cyc_start_o(cyc_start_o),
    .period_o   (period_o)
);

// File: tb/lafg_freq_gen_tb_top.sv
module lafg_freq_gen_tb_top;
    localparam int FB_W = 8;
    localparam int PER_W = 16;
    localparam int P_NOM = 40;
    localparam int P_FLOOR = 100;
    localparam int TH_NOM = 100;
    localparam int TH_FLOOR = 88;
    localparam int TH_ZDC = 64;
    localparam int TH_RESUME = 70;
    localparam int HOP_SPAN = 4;
    localparam int HOP_SHIFT = 4;
    localparam int STEP = (P_FLOOR - P_NOM) / (TH_NOM - TH_FLOOR);
    localparam int MAXP = 125;
    localparam int N_TBL = 11;

    // Stimulus code and hand-computed base period
    localparam int TBL_FB[N_TBL]   = '{130, 100, 99, 96, 94, 90, 89, 88, 80, 66, 64};
    localparam int TBL_BASE[N_TBL] = '{40, 40, 45, 60, 70, 90, 95, 100, 100, 100, 100};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [FB_W-1:0] fb = 8'd120;
    logic strobe;
    logic [PER_W-1:0] per;

    int n_run = 0;
    int n_fail = 0;
    int mh = 0;
    bit mup = 1'b1;
    int last_per = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    lafg_freq_gen #(
        .FB_W(FB_W), .PER_W(PER_W), .P_NOM(P_NOM), .P_FLOOR(P_FLOOR),
        .TH_NOM(TH_NOM), .TH_FLOOR(TH_FLOOR), .TH_ZDC(TH_ZDC),
        .TH_RESUME(TH_RESUME), .HOP_SPAN(HOP_SPAN), .HOP_SHIFT(HOP_SHIFT)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fb_code_i(fb),
        .cyc_start_o(strobe), .period_o(per)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog (R1..R10 not completed) actual %0d cycles expected < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic int base_of(int f);
        if (f >= TH_NOM) return P_NOM;
        if (f <= TH_FLOOR) return P_FLOOR;
        return P_NOM + (TH_NOM - f) * STEP;
    endfunction

    function automatic int exp_per(int f, int h);
        int b;
        b = base_of(f);
        return b + ((h * b) >>> HOP_SHIFT);
    endfunction

    function automatic string tag_of(int f);
        if (f >= TH_NOM) return "R2";
        if (f <= TH_FLOOR) return "R4";
        return "R3";
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic hop_step();
        if (mup) begin
            mh++;
            if (mh == HOP_SPAN) mup = 1'b0;
        end else begin
            mh--;
            if (mh == -HOP_SPAN) mup = 1'b1;
        end
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!strobe && n < 1000);
    endtask

    task automatic watch(int cycles, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (strobe) seen = 1'b1;
        end
    endtask

    // Apply a code just after a strobe and check the following cycle
    task automatic run_cycle(int f, int exp_base, string tag);
        int n;
        int e;
        fb = FB_W'(f);
        wait_strobe(n);
        chk(n == last_per, "R7", "strobe spacing", n, last_per);
        e = exp_base + ((mh * exp_base) >>> HOP_SHIFT);
        chk(int'(per) == e, tag, "period (R5)", int'(per), e);
        hop_step();
        last_per = int'(per);
    endtask

    task automatic do_reset();
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        fb = 8'd120;
        repeat (3) @(negedge clk);
        chk(strobe == 1'b0, "R1", "strobe in reset", int'(strobe), 0);
        chk(int'(per) == P_NOM, "R1", "period in reset", int'(per), P_NOM);
        mh = 0;
        mup = 1'b1;
        rst_n = 1'b1;
        wait_strobe(n);
        chk(n == P_NOM, "R1", "first strobe delay", n, P_NOM);
        chk(int'(per) == exp_per(120, 0), "R1", "first period, level 0", int'(per), exp_per(120, 0));
        hop_step();
        last_per = int'(per);
    endtask

    initial begin
        int n;
        int e;
        int half;
        int total;
        int pb;
        bit seen;

        do_reset();

        // Vector table walk across the load map
        for (int i = 0; i < N_TBL; i++) begin
            run_cycle(TBL_FB[i], TBL_BASE[i], tag_of(TBL_FB[i]));
        end

        // Dither sweep through both reversal points (R6)
        for (int i = 0; i < 12; i++) begin
            run_cycle(120, P_NOM, "R6");
        end

        // Mid-cycle code change must not alter the running cycle (R7)
        fb = 8'd120;
        half = last_per / 2;
        repeat (half) @(negedge clk);
        fb = 8'd88;
        wait_strobe(n);
        total = half + n;
        chk(total == last_per, "R7", "mid-cycle change spacing", total, last_per);
        e = exp_per(88, mh);
        chk(int'(per) == e, "R7", "period after mid-cycle change", int'(per), e);
        hop_step();
        last_per = int'(per);

        // Burst entry, hysteresis hold, phase-aligned resume (R8, R9, R10)
        fb = 8'd63;
        pb = exp_per(63, mh);
        watch(3 * MAXP, seen);
        chk(!seen, "R8", "strobe during burst", int'(seen), 0);
        fb = 8'd69;
        watch(3 * MAXP, seen);
        chk(!seen, "R9", "strobe below resume code", int'(seen), 0);
        fb = 8'd70;
        wait_strobe(n);
        total = 6 * MAXP + n;
        chk(((total - last_per) % pb) == 0, "R10", "resume phase remainder",
            (total - last_per) % pb, 0);
        e = exp_per(70, mh);
        chk(int'(per) == e, "R10", "resume period, frozen level", int'(per), e);
        hop_step();
        last_per = int'(per);

        // Code exactly at the zero-duty threshold keeps switching (R9)
        run_cycle(64, P_FLOOR, "R9");
        run_cycle(120, P_NOM, "R2");

        // Reset in mid-operation restarts timing and dither (R1)
        do_reset();
        run_cycle(120, P_NOM, "R6");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule